// File: doc/BRIEF.md
# One-Time-Programmable Wiper Controller with Serial Slave

This block is the digital side of a 64-step potentiometer. It holds a 6-bit wiper code and answers as a two-wire I2C slave. SCL and SDA are sampled by the block's own clock, and SDA is driven low only through an open-drain enable. Until the part is locked, a host may rewrite the code as often as it likes. A lock command starts a timed burn of the current code into a one-time fuse store, which sits outside this block and is modelled by the bench. After the burn, the block reads the fuse store back and sets a two-bit verdict. From then on the code cannot change.

A write frame has two bytes. The first is the address byte with R/W = 0. The second is an instruction byte: bit 7 is the lock flag and bits 5:0 are the new code. A read frame returns one status byte, `{verdict[1:0], code[5:0]}`.

The serial engine has these states: IDLE, ADDR (shift in the address), ADDR_ACK, CMD (shift in the instruction), CMD_ACK, TX (shift out status) and TX_ACK (sample the master's acknowledge).
- A START leads to ADDR from any state. A STOP leads to IDLE from any state.
- ADDR goes to ADDR_ACK on a hit while not busy, and to IDLE otherwise.
- ADDR_ACK goes to CMD for a write and to TX for a read.
- CMD_ACK returns to CMD.
- TX_ACK goes back to TX when the master acknowledges, and to IDLE when it does not.

The fuse sequencer has these states: INIT (one cycle after reset, to inspect the store), OPEN (writes accepted), BURN (burn strobe held for a counted window), CHECK (compare the read-back) and LOCKED.
- INIT goes to LOCKED if the store is already programmed, and to OPEN otherwise.
- A lock command moves OPEN to BURN.
- BURN goes to CHECK when its counter expires.
- CHECK moves to LOCKED after one cycle.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: After reset with the fuse store unprogrammed (`fuse_blown_i`=0), `wiper_o` is 0x20 (midscale), `busy_o` is 0 and the verdict reads back as 00.
- R2: The slave answers only address `{ADDR_HI, addr_sel_i}`. Any other address is NACKed and its data byte has no effect on `wiper_o`.
- R3: In OPEN, an instruction byte with bit 7 = 0 sets `wiper_o` to bits 5:0 by the end of its acknowledge, any number of times. Bit 6 is ignored.
- R4: An instruction with bit 7 = 1 in OPEN holds `fuse_burn_o` high for exactly PROG_CYCLES clocks with `fuse_code_o` equal to the current code, and holds `busy_o` high for PROG_CYCLES+1 clocks. Its bits 5:0 are ignored.
- R5: Once locked, write instructions are still acknowledged but `wiper_o` never changes.
- R6: A lock instruction after locking starts no second burn.
- R7: A read returns `{verdict, code}`. The verdict is 11 when the fuse read-back equals the locked code, 10 when it differs, and never 01.
- R8: While `busy_o` is high, the slave NACKs its own address.
- R9: Reset with the store programmed (`fuse_blown_i`=1) loads `wiper_o` from `fuse_code_i`, sets the verdict to 11 and leaves the block locked.
- R10: `sda_oe_o` changes only while SCL is low. START and STOP are recognised as SDA edges while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel_i | input | 1 | Lowest bit of the slave address |
| fuse_blown_i | input | 1 | Fuse store reports programmed |
| fuse_code_i | input | 6 | Fuse store read-back |
| fuse_burn_o | output | 1 | Burn strobe to the fuse store |
| fuse_code_o | output | 6 | Code presented for burning |
| wiper_o | output | 6 | Wiper position |
| busy_o | output | 1 | Fuse programming in progress |

## Verification
The assertions assume a well-formed bus. The master changes SDA only while SCL is low, except for START and STOP, and each SCL phase spans several block clocks so the two-flop sampling sees every level. They also assume the fuse store holds `fuse_code_i` steady outside the burn window. The bench master holds every SCL phase for ten clocks and moves SDA halfway through the low phase. It always ends a frame with STOP before the next START. Its fuse model updates only on the falling clock edge during the burn.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;
    localparam int WIPER_W = 6;
    localparam int BYTE_W  = 8;
    localparam int LOCK_BIT = 7;

    localparam logic [1:0] VERDICT_BLANK = 2'b00;
    localparam logic [1:0] VERDICT_GOOD  = 2'b11;
    localparam logic [1:0] VERDICT_FAULT = 2'b10;

    typedef enum logic [2:0] {
        BUS_IDLE, BUS_ADDR, BUS_ADDR_ACK, BUS_CMD, BUS_CMD_ACK, BUS_TX, BUS_TX_ACK
    } bus_state_t;

    typedef enum logic [2:0] {
        FS_INIT, FS_OPEN, FS_BURN, FS_CHECK, FS_LOCKED
    } fuse_state_t;
endpackage

// File: rtl/otp_line_sync.sv
module otp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_o      = scl_sh[STAGES-1];
    assign sda_o      = sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
    import otp_wiper_pkg::*;
#(
    parameter int PROG_CYCLES = 20_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic               cmd_lock_i,
    input  logic [WIPER_W-1:0] cmd_code_i,
    input  logic               fuse_blown_i,
    input  logic [WIPER_W-1:0] fuse_code_i,
    output logic               fuse_burn_o,
    output logic [WIPER_W-1:0] fuse_code_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic [1:0]         verdict_o,
    output logic               busy_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

    fuse_state_t st_q, st_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [WIPER_W-1:0] wiper_q;
    logic [1:0]         verdict_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FS_INIT:   st_nx = fuse_blown_i ? FS_LOCKED : FS_OPEN;
            FS_OPEN:   if (cmd_valid_i && cmd_lock_i) st_nx = FS_BURN;
            FS_BURN:   if (cnt_q == CNT_LAST) st_nx = FS_CHECK;
            FS_CHECK:  st_nx = FS_LOCKED;
            FS_LOCKED: st_nx = FS_LOCKED;
            default:   st_nx = FS_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_INIT;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q   <= MIDSCALE;
            verdict_q <= VERDICT_BLANK;
            cnt_q     <= '0;
        end else begin
            unique case (st_q)
                FS_INIT: if (fuse_blown_i) begin
                    wiper_q   <= fuse_code_i;
                    verdict_q <= VERDICT_GOOD;
                end
                FS_OPEN: begin
                    cnt_q <= '0;
                    if (cmd_valid_i && !cmd_lock_i) wiper_q <= cmd_code_i;
                end
                FS_BURN:  cnt_q <= cnt_q + 1'b1;
                FS_CHECK: verdict_q <= (fuse_code_i == wiper_q) ? VERDICT_GOOD : VERDICT_FAULT;
                default: ;
            endcase
        end
    end

    assign wiper_o     = wiper_q;
    assign verdict_o   = verdict_q;
    assign fuse_code_o = wiper_q;
    assign fuse_burn_o = (st_q == FS_BURN);
    assign busy_o      = (st_q == FS_BURN) || (st_q == FS_CHECK);

    logic burn_done_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              burn_done_q <= 1'b0;
        else if (st_q == FS_CHECK) burn_done_q <= 1'b1;
    end

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_LOCKED) |=> $stable(wiper_o));
    assert_burn_code_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_burn_o && $past(fuse_burn_o)) |-> $stable(fuse_code_o));
    assert_single_burn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        burn_done_q |-> !fuse_burn_o);
    assert_verdict_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_o != 2'b01);
endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
    import otp_wiper_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b010110,
    parameter int         PROG_CYCLES = 20_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               addr_sel_i,
    input  logic               fuse_blown_i,
    input  logic [WIPER_W-1:0] fuse_code_i,
    output logic               fuse_burn_o,
    output logic [WIPER_W-1:0] fuse_code_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic               busy_o
);
    localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t st_q, st_nx;
    logic [BYTE_W-1:0] rx_q, tx_q, status;
    logic [3:0] bitcnt_q;
    logic rw_q, mack_q, sda_oe_q;
    logic addr_hit, byte_end, cmd_valid;
    logic [1:0] verdict;

    otp_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det)
    );

    assign addr_hit  = (rx_q[BYTE_W-1:1] == {ADDR_HI, addr_sel_i});
    assign byte_end  = scl_fall && (bitcnt_q == BITS_DONE);
    assign cmd_valid = (st_q == BUS_CMD) && byte_end && !start_det && !stop_det;
    assign status    = {verdict, wiper_o};

    always_comb begin
        st_nx = st_q;
        if (stop_det)       st_nx = BUS_IDLE;
        else if (start_det) st_nx = BUS_ADDR;
        else begin
            unique case (st_q)
                BUS_IDLE:     st_nx = BUS_IDLE;
                BUS_ADDR:     if (byte_end) st_nx = (addr_hit && !busy_o) ? BUS_ADDR_ACK : BUS_IDLE;
                BUS_ADDR_ACK: if (scl_fall) st_nx = rw_q ? BUS_TX : BUS_CMD;
                BUS_CMD:      if (byte_end) st_nx = BUS_CMD_ACK;
                BUS_CMD_ACK:  if (scl_fall) st_nx = BUS_CMD;
                BUS_TX:       if (byte_end) st_nx = BUS_TX_ACK;
                BUS_TX_ACK:   if (scl_fall) st_nx = mack_q ? BUS_TX : BUS_IDLE;
                default:      st_nx = BUS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0; tx_q <= '0; bitcnt_q <= '0;
            rw_q <= 1'b0; mack_q <= 1'b0; sda_oe_q <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (st_q)
                BUS_ADDR, BUS_CMD: begin
                    if (scl_rise) begin
                        rx_q     <= {rx_q[BYTE_W-2:0], sda_s};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_end) begin
                        if (st_q == BUS_CMD) sda_oe_q <= 1'b1;
                        else if (addr_hit && !busy_o) begin
                            sda_oe_q <= 1'b1;
                            rw_q     <= rx_q[0];
                        end
                    end
                end
                BUS_ADDR_ACK: if (scl_fall) begin
                    bitcnt_q <= '0;
                    tx_q     <= status;
                    sda_oe_q <= rw_q ? ~status[BYTE_W-1] : 1'b0;
                end
                BUS_CMD_ACK: if (scl_fall) begin
                    bitcnt_q <= '0;
                    sda_oe_q <= 1'b0;
                end
                BUS_TX: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt_q == BITS_DONE) sda_oe_q <= 1'b0;
                        else begin
                            sda_oe_q <= ~tx_q[BYTE_W-2];
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                BUS_TX_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall && mack_q) begin
                        bitcnt_q <= '0;
                        tx_q     <= status;
                        sda_oe_q <= ~status[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe_q;

    otp_fuse_seq #(.PROG_CYCLES(PROG_CYCLES)) u_fuse (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_lock_i(rx_q[LOCK_BIT]),
        .cmd_code_i(rx_q[WIPER_W-1:0]),
        .fuse_blown_i(fuse_blown_i), .fuse_code_i(fuse_code_i),
        .fuse_burn_o(fuse_burn_o), .fuse_code_o(fuse_code_o),
        .wiper_o(wiper_o), .verdict_o(verdict), .busy_o(busy_o)
    );

    assert_ack_never_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BUS_ADDR_ACK) |-> !busy_o);
    assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);
    assert_oe_fall_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_s);
endmodule

// File: tb/test_otp_wiper_ctrl.sv
`timescale 1ns/1ps
module test_otp_wiper_ctrl;
    localparam int PROG = 400;
    localparam int H    = 10;
    localparam logic [6:0] ADR0 = 7'h2C;
    localparam logic [6:0] ADR1 = 7'h2D;

    logic clk = 0;
    always #2.5 clk = ~clk;

    logic rst_n = 0, scl_m = 1, sda_m = 1, addr_sel = 0;
    logic fblown = 0;
    logic [5:0] fmem = 0, fmask = 0;
    logic sda_oe, fburn, busy;
    logic [5:0] fcode, wiper;
    wire sda_bus = sda_m & ~sda_oe;

    otp_wiper_ctrl #(.PROG_CYCLES(PROG)) i_otp_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .fuse_blown_i(fblown), .fuse_code_i(fmem),
        .fuse_burn_o(fburn), .fuse_code_o(fcode), .wiper_o(wiper), .busy_o(busy)
    );

    int nchk = 0, nerr = 0, burn_cyc = 0, busy_cyc = 0, r10_viol = 0;
    logic oe_prev = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (fburn) begin fmem = fcode ^ fmask; fblown = 1; burn_cyc++; end
        if (busy) busy_cyc++;
        if (scl_m && sda_oe !== oe_prev) r10_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n); repeat (n) @(negedge clk); endtask

    task automatic bit_out(logic b);
        sda_m = b; tick(H/2); scl_m = 1; tick(H); scl_m = 0; tick(H/2);
    endtask
    task automatic bit_in(output logic b);
        sda_m = 1; tick(H/2); scl_m = 1; tick(H/2); b = sda_bus; tick(H/2); scl_m = 0; tick(H/2);
    endtask
    task automatic i2c_start;
        sda_m = 1; scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H/2);
    endtask
    task automatic i2c_stop;
        sda_m = 0; tick(H/2); scl_m = 1; tick(H); sda_m = 1; tick(H);
    endtask
    task automatic send_byte(logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x); ack = !x;
    endtask
    task automatic recv_byte(output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
        bit_out(1'b1);
    endtask
    task automatic do_write(logic [6:0] a, logic [7:0] d, output logic aa, output logic ad);
        i2c_start; send_byte({a, 1'b0}, aa);
        if (aa) send_byte(d, ad); else ad = 0;
        i2c_stop;
    endtask
    task automatic do_read(logic [6:0] a, output logic aa, output logic [7:0] b);
        i2c_start; send_byte({a, 1'b1}, aa);
        b = 8'hxx;
        if (aa) recv_byte(b);
        i2c_stop;
    endtask

    logic [7:0] exp_q[$], got_q[$];
    string tag_q[$];

    task automatic expect_read(logic [7:0] e, string tag);
        logic aa; logic [7:0] b;
        exp_q.push_back(e); tag_q.push_back(tag);
        do_read(ADR0, aa, b);
        chk({tag, " read ack"}, aa, 1);
        got_q.push_back(b);
    endtask

    initial begin
        forever begin
            wait (got_q.size() > 0);
            chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic do_reset; rst_n = 0; tick(5); rst_n = 1; tick(5); endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run;
    end

    initial begin
        logic aa, ad;
        tick(3); do_reset;
        chk("R1 wiper midscale", wiper, 6'h20);
        chk("R1 busy low", busy, 0);
        expect_read({2'b00, 6'h20}, "R1 R7 blank status");

        do_write(ADR0, 8'h15, aa, ad);
        chk("R3 ack", {aa, ad}, 2'b11);
        chk("R3 write 15", wiper, 6'h15);
        do_write(ADR0, 8'h7F, aa, ad);
        chk("R3 bit6 ignored", wiper, 6'h3F);
        do_write(ADR0, 8'h00, aa, ad);
        chk("R3 write zero", wiper, 6'h00);

        do_write(ADR1, 8'h0A, aa, ad);
        chk("R2 foreign address nack", aa, 0);
        chk("R2 no effect", wiper, 6'h00);
        addr_sel = 1;
        do_write(ADR1, 8'h0B, aa, ad);
        chk("R2 select high ack", aa, 1);
        chk("R2 select high write", wiper, 6'h0B);
        addr_sel = 0;

        do_write(ADR0, 8'h2A, aa, ad);
        burn_cyc = 0; busy_cyc = 0;
        do_write(ADR0, 8'h85, aa, ad);
        chk("R4 lock acked", ad, 1);
        chk("R4 busy raised", busy, 1);
        begin
            logic [7:0] b;
            do_read(ADR0, aa, b);
            chk("R8 nack while busy", aa, 0);
        end
        wait (!busy); tick(5);
        chk("R4 burn length", burn_cyc, PROG);
        chk("R4 busy length", busy_cyc, PROG + 1);
        chk("R4 burned code", fmem, 6'h2A);
        chk("R4 data field ignored", wiper, 6'h2A);
        expect_read({2'b11, 6'h2A}, "R7 good verdict");

        do_write(ADR0, 8'h11, aa, ad);
        chk("R5 write acked", ad, 1);
        chk("R5 frozen", wiper, 6'h2A);
        burn_cyc = 0;
        do_write(ADR0, 8'h80, aa, ad);
        tick(PROG + 50);
        chk("R6 no second burn", burn_cyc, 0);
        chk("R6 not busy", busy, 0);

        do_reset;
        chk("R9 loaded from fuse", wiper, 6'h2A);
        expect_read({2'b11, 6'h2A}, "R9 verdict after reset");
        do_write(ADR0, 8'h05, aa, ad);
        chk("R9 still locked", wiper, 6'h2A);

        fblown = 0; fmem = 0; fmask = 6'h04;
        do_reset;
        chk("R1 midscale again", wiper, 6'h20);
        do_write(ADR0, 8'h33, aa, ad);
        do_write(ADR0, 8'h80, aa, ad);
        wait (!busy); tick(5);
        expect_read({2'b10, 6'h33}, "R7 fault verdict");
        chk("R5 code kept after fault", wiper, 6'h33);

        chk("R10 sda moves only with scl low", r10_viol, 0);
        wait (got_q.size() == 0); tick(5);
        finish_run;
    end
endmodule